// File: doc/BRIEF.md
# Eight-Operation 16-Bit ALU

This block is the arithmetic core of a small 16-bit processor datapath. It is purely combinational. A 3-bit operation code selects one of eight results computed from two operands. The register-type and immediate instructions use it for bitwise logic, wrapping add and subtract, variable shifts and a signed set-less-than. Two flags sit beside the result. One reports signed overflow of an add or subtract. The other reports operand equality, and branch logic reads it whatever operation is selected.

The block has no clock, no handshake and no stored state. Its outputs follow its inputs within the same cycle. The surrounding pipeline registers them where it needs to. The operand width is a parameter and defaults to 16. The shift amount is the low log2(width) bits of the second operand.

Top module: `alu16_core`

## Requirements
- R1: Code 0 gives x OR y, and code 1 gives x AND y, bit by bit.
- R2: Code 2 gives x + y, keeping the low 16 bits (the sum wraps around).
- R3: Code 3 gives x - y, keeping the low 16 bits (the difference wraps around).
- R4: ovf_flag is 1 only when the code is 2 or 3 and the two's-complement result does not fit in 16 bits. It is 0 for every other code.
- R5: Code 4 shifts x left by the shift amount and fills with zeros.
- R6: Code 5 shifts x right and fills with zeros. Code 6 shifts x right and fills with copies of bit 15.
- R7: Code 7 gives 16'h0001 when x < y as signed values, and 16'h0000 otherwise. The answer is correct even when x - y overflows.
- R8: eq_flag is 1 exactly when x equals y, under every operation code.
- R9: The shift amount is y[3:0]. Bits y[15:4] do not change the result of codes 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 16 | First operand, and the value that is shifted |
| opnd_y | input | 16 | Second operand; its low four bits are the shift amount |
| op_sel | input | 3 | Operation code, 0 to 7 |
| result | output | 16 | Selected result |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| eq_flag | output | 1 | High when the operands are equal |

## Verification
The embedded assertions are checked on every input change:
- the overflow flag agrees with a 17-bit signed sum or difference, and is never set outside add and subtract;
- a set-less-than result never has a bit set above bit 0;
- a zero shift returns x unchanged;
- subtracting equal operands gives zero with no overflow.

Only the bench's scenarios show the following:
- the operation code mapping;
- the fill bit of each shift direction;
- the signed comparison at the overflow edges, such as 16'h8000 against 16'h7FFF;
- that the upper bits of y are ignored by the shifts.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_OR  = 3'd0,
    OP_AND = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_SLL = 3'd4,
    OP_SRL = 3'd5,
    OP_SRA = 3'd6,
    OP_SLT = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  shift_mode_e    mode,
  output logic [W-1:0]   dout
);
  logic       fill;
  logic [W-1:0] stage [SHW+1];

  assign fill     = (mode == SH_RARI) ? din[W-1] : 1'b0;
  assign stage[0] = din;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [W-1:0] moved;
    always_comb begin
      if (mode == SH_LEFT) moved = {stage[i][W-1-S:0], {S{1'b0}}};
      else                 moved = {{S{fill}}, stage[i][W-1:S]};
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SHW];

  always_comb begin
    if (amt == '0) p_shift_zero_r5: assert (dout == din);
  end
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same,
  output logic         lt_s
);
  always_comb begin
    same = ~|(a ^ b);
    lt_s = $signed(a) < $signed(b);
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opnd_x,
  input  logic [DATA_W-1:0] opnd_y,
  input  logic [2:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              ovf_flag,
  output logic              eq_flag
);
  localparam int SHW = $clog2(DATA_W);

  alu_op_e           op;
  logic [DATA_W-1:0] arith_out, shift_out;
  logic              arith_ovf, is_eq, is_lt;
  shift_mode_e       smode;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    case (op)
      OP_SRL:  smode = SH_RLOG;
      OP_SRA:  smode = SH_RARI;
      default: smode = SH_LEFT;
    endcase
  end

  alu16_addsub #(.W(DATA_W)) u_addsub (
    .a(opnd_x), .b(opnd_y), .sub(op == OP_SUB),
    .sum(arith_out), .ovf(arith_ovf)
  );

  alu16_shift #(.W(DATA_W), .SHW(SHW)) u_shift (
    .din(opnd_x), .amt(opnd_y[SHW-1:0]), .mode(smode), .dout(shift_out)
  );

  alu16_cmp #(.W(DATA_W)) u_cmp (
    .a(opnd_x), .b(opnd_y), .same(is_eq), .lt_s(is_lt)
  );

  always_comb begin
    case (op)
      OP_OR:                  result = opnd_x | opnd_y;
      OP_AND:                 result = opnd_x & opnd_y;
      OP_ADD, OP_SUB:         result = arith_out;
      OP_SLL, OP_SRL, OP_SRA: result = shift_out;
      default:                result = {{(DATA_W-1){1'b0}}, is_lt};
    endcase
    ovf_flag = ((op == OP_ADD) || (op == OP_SUB)) && arith_ovf;
    eq_flag  = is_eq;
  end

  logic signed [DATA_W:0] wide_add, wide_sub;
  assign wide_add = {opnd_x[DATA_W-1], opnd_x} + {opnd_y[DATA_W-1], opnd_y};
  assign wide_sub = {opnd_x[DATA_W-1], opnd_x} - {opnd_y[DATA_W-1], opnd_y};

  always_comb begin
    if (op == OP_ADD)
      p_add_ovf_r4: assert (ovf_flag == (wide_add[DATA_W] != wide_add[DATA_W-1]));
    if (op == OP_SUB)
      p_sub_ovf_r4: assert (ovf_flag == (wide_sub[DATA_W] != wide_sub[DATA_W-1]));
    if ((op != OP_ADD) && (op != OP_SUB))
      p_no_overflow_r4: assert (!ovf_flag);
    if (op == OP_SLT)
      p_slt_zext_r7: assert (result[DATA_W-1:1] == '0);
    if ((op == OP_SUB) && eq_flag)
      p_sub_equal_r3: assert ((result == '0) && !ovf_flag);
  end
endmodule

// File: tb/sim_alu16_core.sv
module sim_alu16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x, y;
  logic [2:0]  sel;
  logic [15:0] res;
  logic        ovf, eq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu16_core u0 (
    .opnd_x(x), .opnd_y(y), .op_sel(sel),
    .result(res), .ovf_flag(ovf), .eq_flag(eq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    sel = s; x = a; y = b;
    #5;
  endtask

  task automatic t_reset;
    apply(3'd0, 16'h0000, 16'h0000);
    chk("R1 reset result", res, 16'h0000);
    chk("R8 reset eq", {15'd0, eq}, 16'd1);
    chk("R4 reset ovf", {15'd0, ovf}, 16'd0);
  endtask

  task automatic t_logic;
    apply(3'd0, 16'hA5F0, 16'h0F0F); chk("R1 or", res, 16'hAFFF);
    apply(3'd1, 16'hA5F0, 16'h0F0F); chk("R1 and", res, 16'h0500);
  endtask

  task automatic t_add;
    apply(3'd2, 16'h1234, 16'h1111); chk("R2 add", res, 16'h2345);
    chk("R4 add no ovf", {15'd0, ovf}, 16'd0);
    apply(3'd2, 16'h7FFF, 16'h0001); chk("R2 add wrap", res, 16'h8000);
    chk("R4 add pos ovf", {15'd0, ovf}, 16'd1);
    apply(3'd2, 16'h8000, 16'h8000); chk("R2 add neg", res, 16'h0000);
    chk("R4 add neg ovf", {15'd0, ovf}, 16'd1);
    apply(3'd2, 16'hFFFF, 16'h0001); chk("R4 carry not ovf", {15'd0, ovf}, 16'd0);
  endtask

  task automatic t_sub;
    apply(3'd3, 16'h0005, 16'h0007); chk("R3 sub", res, 16'hFFFE);
    chk("R4 sub no ovf", {15'd0, ovf}, 16'd0);
    apply(3'd3, 16'h8000, 16'h0001); chk("R3 sub wrap", res, 16'h7FFF);
    chk("R4 sub ovf", {15'd0, ovf}, 16'd1);
    apply(3'd3, 16'h0000, 16'h8000); chk("R4 sub ovf2", {15'd0, ovf}, 16'd1);
  endtask

  task automatic t_shift;
    apply(3'd4, 16'h8421, 16'h0004); chk("R5 sll", res, 16'h4210);
    apply(3'd4, 16'h0001, 16'h000F); chk("R5 sll 15", res, 16'h8000);
    chk("R4 shift ovf", {15'd0, ovf}, 16'd0);
    apply(3'd5, 16'h8421, 16'h0004); chk("R6 srl", res, 16'h0842);
    apply(3'd6, 16'h8421, 16'h0004); chk("R6 sra neg", res, 16'hF842);
    apply(3'd6, 16'h4000, 16'h000E); chk("R6 sra pos", res, 16'h0001);
    apply(3'd6, 16'hBEEF, 16'h0000); chk("R6 sra zero", res, 16'hBEEF);
  endtask

  task automatic t_slt;
    apply(3'd7, 16'hFFFF, 16'h0001); chk("R7 slt neg<pos", res, 16'h0001);
    apply(3'd7, 16'h0001, 16'hFFFF); chk("R7 slt pos>neg", res, 16'h0000);
    apply(3'd7, 16'h8000, 16'h7FFF); chk("R7 slt ovf edge", res, 16'h0001);
    apply(3'd7, 16'h7FFF, 16'h8000); chk("R7 slt ovf edge2", res, 16'h0000);
    apply(3'd7, 16'h1234, 16'h1234); chk("R7 slt equal", res, 16'h0000);
  endtask

  task automatic t_eq;
    for (int s = 0; s < 8; s++) begin
      apply(s[2:0], 16'h5A5A, 16'h5A5A); chk("R8 eq high", {15'd0, eq}, 16'd1);
      apply(s[2:0], 16'h5A5A, 16'h5A5B); chk("R8 eq low", {15'd0, eq}, 16'd0);
    end
  endtask

  task automatic t_amount_mask;
    apply(3'd4, 16'h00F1, 16'hFFF3); chk("R9 sll mask", res, 16'h0788);
    apply(3'd5, 16'hF000, 16'h0013); chk("R9 srl mask", res, 16'h1E00);
    apply(3'd6, 16'h8000, 16'h8010); chk("R9 sra mask", res, 16'h8000);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    x = '0; y = '0; sel = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset;
    t_logic;
    t_add;
    t_sub;
    t_shift;
    t_slt;
    t_eq;
    t_amount_mask;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule